// File: doc/BRIEF.md
# JTAG Register Access Bridge

This block is a test access port that lets a scan controller reach a small register file and two attached sub-block ports. A standard 16-state controller is driven by TCK and TMS. A 4-bit instruction register picks what the data path does. Instruction 0x8 selects the local register file. Instructions 0x5 and 0x6 forward commands to sub-block ports 1 and 2. Every other instruction selects a one-bit bypass stage.

Each command is one 66-bit data-register scan. Bit 65 enables the command. Bit 64 gives the direction. Bits 63:32 hold the address and bits 31:0 hold the data. A write takes one scan. A read takes two scans. The first scan names the address, and the block latches the result when that scan's update runs. The second scan has the enable bit cleared, and the result comes out on TDO in its low 32 bits. A read of the parallel-read register at 0x18 also places the value on a 32-bit output bus.

The whole block runs on TCK. Two active-low resets are provided. TRSTN resets the controller and the instruction register. A separate system reset clears the register file, the read results and the parallel bus.

Top module: `jtag_reg_bridge`

## Requirements
- R1: Asserting trst_n low, or five TCK rising edges with TMS high, puts the controller in Test-Logic-Reset. That state loads the instruction register with 0xF, which selects bypass.
- R2: Capture-IR loads the 4-bit pattern 0001 into the instruction shift stage. It is shifted out LSB first on TDO, and Update-IR loads the 4 bits shifted in from TDI.
- R3: Any instruction other than 0x8, 0x5 and 0x6 selects a 1-bit bypass stage. This stage captures 0 in Capture-DR and delays TDI by one shift cycle.
- R4: With instruction 0x8, a data scan of enable=1, read=0, address A and data D writes D into the local register at A on Update-DR. The local registers sit at word addresses 0x00 to 0x20.
- R5: With instruction 0x8, a data scan of enable=1, read=1 and address A latches the value of A on Update-DR. The next Capture-DR loads that value into bits 31:0 and zeros into bits 65:32, and these bits are shifted out LSB first.
- R6: A data scan with enable (bit 65) at 0 performs no register access and leaves the latched read result unchanged.
- R7: An address that is above 0x20, that has a nonzero bit 0 or bit 1, or that has any bit set above bit 5 is unmapped. Writes to it are ignored and reads of it return zero.
- R8: A read of address 0x18 loads its value onto pbus. pbus holds that value until the next read of 0x18 or a system reset.
- R9: With instruction 0x5 (port 1) or 0x6 (port 2), a data scan with bit 65 set raises only that port's bit of sub_stb (bit 0 for port 1, bit 1 for port 2) for exactly one TCK cycle after Update-DR. sub_we carries bit 64 (1 means write), sub_addr carries bits 63:32, and sub_wdata carries bits 31:0.
- R10: For a sub-block read (bit 64 = 0), the port's sub_rdata is latched while its strobe is high. The next Capture-DR under that port's instruction loads it into bits 31:0.
- R11: While sys_rst_n is low, all local registers, both latched read results and pbus are zero.
- R12: TDO changes only on the falling edge of TCK and is 0 whenever the controller is outside Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, which clocks the whole block |
| trst_n | input | 1 | Asynchronous active-low test-port reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the register-file side |
| pbus | output | 32 | Parallel copy of the last read of address 0x18 |
| sub_stb | output | 2 | One-cycle command strobe per sub-block port |
| sub_we | output | 1 | Sub-block command direction, 1 = write |
| sub_addr | output | 32 | Sub-block command address |
| sub_wdata | output | 32 | Sub-block write data |
| sub_rdata1 | input | 32 | Read data from sub-block port 1 |
| sub_rdata2 | input | 32 | Read data from sub-block port 2 |

## Verification
The assertions check four things on every cycle: that TDO stays 0 outside the shift states, and that the instruction register changes only in Update-IR or Test-Logic-Reset. They also check that the sub-block strobes are one-hot single-cycle pulses, and that pbus moves only after an Update-DR. Address decoding, the two-scan read order, enable-clear scans that leave state alone, the bypass delay and the clearing effect of system reset show only in the bench's scan sequences. There, each shifted-out value is compared with a value worked out from the command that was sent.

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IRW = 4
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  input  logic          sys_rst_n,
  output logic [DW-1:0] pbus,
  output logic [1:0]    sub_stb,
  output logic          sub_we,
  output logic [AW-1:0] sub_addr,
  output logic [DW-1:0] sub_wdata,
  input  logic [DW-1:0] sub_rdata1,
  input  logic [DW-1:0] sub_rdata2
);
  localparam int DRW = AW + DW + 2;
  localparam int EN_B = DRW - 1;
  localparam int RD_B = DRW - 2;
  localparam logic [IRW-1:0] IR_LOCAL = IRW'(8);
  localparam logic [IRW-1:0] IR_SUB1  = IRW'(5);
  localparam logic [IRW-1:0] IR_SUB2  = IRW'(6);
  localparam logic [AW-1:0]  PAR_ADDR = AW'(32'h18);
  localparam int LAST_IDX = 8;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PSDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PSIR, S_EX2IR, S_UPIR
  } tap_t;

  tap_t st, nx;
  logic [IRW-1:0] ir, ir_sr;
  logic [DRW-1:0] sr;
  logic           bp;
  logic [DW-1:0]  rf [0:15];
  logic [DW-1:0]  rd_q, sub_rd1, sub_rd2;

  always_comb begin
    case (st)
      S_TLR:   nx = tms ? S_TLR   : S_RTI;
      S_RTI:   nx = tms ? S_SELDR : S_RTI;
      S_SELDR: nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nx = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  nx = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nx = tms ? S_SELDR : S_RTI;
      S_SELIR: nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nx = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  nx = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: nx = tms ? S_UPIR  : S_SHIR;
      default: nx = tms ? S_SELDR : S_RTI;
    endcase
  end

  wire sel_local = (ir == IR_LOCAL);
  wire sel_sub1  = (ir == IR_SUB1);
  wire sel_sub2  = (ir == IR_SUB2);
  wire sel_reg   = sel_local | sel_sub1 | sel_sub2;

  wire [AW-1:0] cmd_addr = sr[RD_B-1:DW];
  wire [3:0]    cmd_idx  = cmd_addr[5:2];
  wire          mapped   = (cmd_addr[AW-1:6] == '0) && (cmd_addr[1:0] == 2'b00)
                           && (int'(cmd_idx) <= LAST_IDX);
  wire [DW-1:0] rf_val   = mapped ? rf[cmd_idx] : '0;
  wire          upd_cmd  = (st == S_UPDR) && sr[EN_B];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st    <= S_TLR;
      ir    <= '1;
      ir_sr <= '0;
      sr    <= '0;
      bp    <= 1'b0;
    end else begin
      st <= nx;
      if (st == S_TLR) ir <= '1;
      else if (st == S_UPIR) ir <= ir_sr;
      if (st == S_CAPIR) ir_sr <= IRW'(1);
      else if (st == S_SHIR) ir_sr <= {tdi, ir_sr[IRW-1:1]};
      if (st == S_CAPDR) begin
        bp <= 1'b0;
        if (sel_local)     sr <= {{(DRW-DW){1'b0}}, rd_q};
        else if (sel_sub1) sr <= {{(DRW-DW){1'b0}}, sub_rd1};
        else if (sel_sub2) sr <= {{(DRW-DW){1'b0}}, sub_rd2};
      end else if (st == S_SHDR) begin
        bp <= tdi;
        if (sel_reg) sr <= {tdi, sr[DRW-1:1]};
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)          tdo <= 1'b0;
    else if (st == S_SHIR) tdo <= ir_sr[0];
    else if (st == S_SHDR) tdo <= sel_reg ? sr[0] : bp;
    else                   tdo <= 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sub_stb   <= '0;
      sub_we    <= 1'b0;
      sub_addr  <= '0;
      sub_wdata <= '0;
    end else begin
      sub_stb <= {upd_cmd & sel_sub2, upd_cmd & sel_sub1};
      if (upd_cmd && (sel_sub1 || sel_sub2)) begin
        sub_we    <= sr[RD_B];
        sub_addr  <= cmd_addr;
        sub_wdata <= sr[DW-1:0];
      end
    end
  end

  always_ff @(posedge tck or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] <= '0;
      rd_q    <= '0;
      sub_rd1 <= '0;
      sub_rd2 <= '0;
      pbus    <= '0;
    end else begin
      if (upd_cmd && sel_local) begin
        if (sr[RD_B]) begin
          rd_q <= rf_val;
          if (cmd_addr == PAR_ADDR) pbus <= rf_val;
        end else if (mapped) begin
          rf[cmd_idx] <= sr[DW-1:0];
        end
      end
      if (sub_stb[0] && !sub_we) sub_rd1 <= sub_rdata1;
      if (sub_stb[1] && !sub_we) sub_rd2 <= sub_rdata2;
    end
  end

  a_r12_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_SHDR && st != S_SHIR) |-> (tdo == 1'b0));

  a_r2_ir_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_UPIR && st != S_TLR) |=> $stable(ir));

  a_r9_stb_onehot: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(sub_stb));

  a_r9_stb_pulse: assert property (@(posedge tck) disable iff (!trst_n)
    (sub_stb != 2'b00) |=> (sub_stb == 2'b00));

  a_r8_pbus_update: assert property (@(posedge tck) disable iff (!trst_n || !sys_rst_n)
    !$stable(pbus) |-> ($past(st) == S_UPDR));
endmodule

// File: tb/jtag_reg_bridge_test.sv
module jtag_reg_bridge_test;
  localparam int PERIOD = 10;
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'hA5A5_0001},
    {32'h0000_000C, 32'h1234_5678},
    {32'h0000_0020, 32'hDEAD_BEEF},
    {32'h0000_0024, 32'h5555_AAAA},
    {32'h0000_000E, 32'h0F0F_0F0F},
    {32'h0000_0010, 32'h8000_0001}
  };

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0, sys_rst_n = 0;
  logic tdo, sub_we;
  logic [31:0] pbus, sub_addr, sub_wdata, sub_rdata1, sub_rdata2;
  logic [1:0] sub_stb;
  int checks = 0, fails = 0;
  int cnt1 = 0, cnt2 = 0;
  logic last_we;
  logic [31:0] last_addr, last_wdata;

  jtag_reg_bridge uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .sys_rst_n(sys_rst_n), .pbus(pbus), .sub_stb(sub_stb), .sub_we(sub_we),
    .sub_addr(sub_addr), .sub_wdata(sub_wdata),
    .sub_rdata1(sub_rdata1), .sub_rdata2(sub_rdata2)
  );

  always #(PERIOD/2) tck = ~tck;

  assign sub_rdata1 = sub_addr ^ 32'h1111_0000;
  assign sub_rdata2 = sub_addr ^ 32'h2222_0000;

  always @(posedge tck) begin
    if (sub_stb[0]) cnt1++;
    if (sub_stb[1]) cnt2++;
    if (sub_stb != 0) begin
      last_we = sub_we; last_addr = sub_addr; last_wdata = sub_wdata;
    end
  end

  task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    o = tdo;
    tms = m;
    tdi = d;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(0, 0, o);
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
  endtask

  task automatic scan_ir(input logic [3:0] v, output logic [3:0] out);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, v[i], o);
      out[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [65:0] v, output logic [65:0] out);
    logic o;
    out = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, v[i], o);
      out[i] = o;
    end
    step(1, 0, o); step(0, 0, o); idle(2);
  endtask

  function automatic logic [65:0] cmd(input logic en, input logic rw, input logic [31:0] a, input logic [31:0] d);
    return {en, rw, a, d};
  endfunction

  function automatic logic is_mapped(input logic [31:0] a);
    return (a[31:6] == 0) && (a[1:0] == 0) && (a <= 32'h20);
  endfunction

  task automatic rd_local(input logic [31:0] a, output logic [65:0] out);
    logic [65:0] junk;
    scan_dr(66, cmd(1, 1, a, 0), junk);
    scan_dr(66, cmd(0, 0, 0, 0), out);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] irout;
    logic [65:0] out;
    logic o;
    #(PERIOD * 2 + 2);
    trst_n = 1; sys_rst_n = 1;
    check("R12 reset tdo", {65'b0, tdo}, 66'b0);
    check("R11 reset pbus", {34'b0, pbus}, 66'b0);
    tap_reset();

    // R1/R3: after reset the DR path is bypass: capture 0 then one-cycle delay
    scan_dr(8, 66'hB5, out);
    check("R3 bypass after R1 reset", out & 66'hFF, 66'h6A);

    // R2: Capture-IR pattern
    scan_ir(4'h8, irout);
    check("R2 capture-ir", {62'b0, irout}, 66'h1);

    // R4/R7 vector loop: writes then reads
    for (int i = 0; i < NV; i++)
      scan_dr(66, cmd(1, 0, VEC[i][63:32], VEC[i][31:0]), out);
    for (int i = 0; i < NV; i++) begin
      rd_local(VEC[i][63:32], out);
      check(is_mapped(VEC[i][63:32]) ? "R4 R5 write/read" : "R7 unmapped",
            out, is_mapped(VEC[i][63:32]) ? {34'b0, VEC[i][31:0]} : 66'b0);
    end

    // R12: tdo is 0 while idling
    step(0, 1, o);
    check("R12 tdo idle", {65'b0, o}, 66'b0);

    // R6: enable-clear scan does not write
    scan_dr(66, cmd(1, 0, 32'h4, 32'hCAFE_0004), out);
    scan_dr(66, cmd(0, 0, 32'h4, 32'h0BAD_0BAD), out);
    rd_local(32'h4, out);
    check("R6 no write with enable=0", out, {34'b0, 32'hCAFE_0004});
    scan_dr(66, cmd(0, 1, 32'h0, 32'h0), out);
    check("R6 read result kept", out, {34'b0, 32'hCAFE_0004});

    // R8: parallel read
    scan_dr(66, cmd(1, 0, 32'h18, 32'h7777_1818), out);
    check("R8 pbus before read", {34'b0, pbus}, 66'b0);
    rd_local(32'h18, out);
    check("R8 pbus after read", {34'b0, pbus}, {34'b0, 32'h7777_1818});
    check("R8 tdo read", out, {34'b0, 32'h7777_1818});
    rd_local(32'hC, out);
    check("R8 pbus held", {34'b0, pbus}, {34'b0, 32'h7777_1818});

    // R9/R10: sub-block ports
    scan_ir(4'h5, irout);
    scan_dr(66, cmd(1, 1, 32'h40, 32'h0000_1234), out);
    check("R9 port1 strobe count", {34'b0, 32'(cnt1), 32'(cnt2)}, {34'b0, 32'd1, 32'd0});
    check("R9 port1 fields", {1'b0, last_we, last_addr, last_wdata}, {2'b01, 32'h40, 32'h1234});
    scan_ir(4'h6, irout);
    scan_dr(66, cmd(1, 0, 32'h80, 32'h0), out);
    scan_dr(66, cmd(0, 0, 0, 0), out);
    check("R10 port2 read data", out, {34'b0, 32'h2222_0080});
    check("R9 port2 strobe only", {34'b0, 32'(cnt1), 32'(cnt2)}, {34'b0, 32'd1, 32'd1});

    // R11: system reset clears state
    @(negedge tck); sys_rst_n = 0;
    @(negedge tck); @(negedge tck); sys_rst_n = 1;
    check("R11 pbus cleared", {34'b0, pbus}, 66'b0);
    scan_dr(66, cmd(0, 0, 0, 0), out);
    check("R11 sub read result cleared", out, 66'b0);
    scan_ir(4'h8, irout);
    rd_local(32'hC, out);
    check("R11 register cleared", out, 66'b0);

    // R1: trst_n returns to bypass
    @(negedge tck); trst_n = 0;
    @(negedge tck); trst_n = 1;
    idle(1);
    scan_dr(4, 66'hF, out);
    check("R1 trst bypass", out & 66'hF, 66'hE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule